// File: doc/BRIEF.md
# Three-Lane Packet Memory Bus Serializer

This block turns memory requests into fixed-length packets for a narrow memory bus that moves data on both halves of its clock. It runs on an internal beat clock at twice the bus rate, so every register uses a single edge. One beat is one half bus cycle, and a packet is eight beats (four bus cycles). Three independent lanes carry the packets: a 3-bit row lane, a 5-bit column lane and an 18-bit data lane. The data lane holds 16 data bits plus 2 byte-parity bits. A parameter removes the parity and leaves a 16-bit lane.

A request is accepted only at a packet boundary. Its row packet goes out in the next slot, its column packet in the slot after that, and for a write its data packet in the third slot. Requests accepted in consecutive slots therefore overlap across the lanes. A loopback deserializer, one per lane, rebuilds every packet from its beats so the whole path can be checked bit for bit.

Top module: `pkt_bus_link`

## Requirements
- R1: A request is accepted only when `slotOpen` is high. `slotOpen` is high in the last beat of every 8-beat slot and never in two consecutive cycles. `reqValid` in any other cycle is ignored and produces no packet.
- R2: The row packet is 24 bits: bit 0 = command (read 0, write 1), bits 12:1 = `reqRow`, bits 23:13 = 0. Beat b carries packet bits [3b+2:3b], lowest bits first. Beat 0 of the packet appears in the cycle right after acceptance.
- R3: The column packet is 40 bits: bit 0 = command, bits 20:1 = `reqCol`, bits 39:21 = 0. It is sent 5 bits per beat, lowest bits first, starting exactly 8 cycles after the row packet starts.
- R4: A write's data packet starts exactly 8 cycles after its column packet starts. In beat b, lane bits 15:0 = `reqData[16b+15:16b]`, lane bit 16 = XOR of that slice's bits 7:0, and lane bit 17 = XOR of its bits 15:8.
- R5: A read request sends no data packet. `dataStart` stays low and the data lane stays zero in the slot where a write's data packet would go.
- R6: Each lane's start flag is high only in beat 0 of a packet on that lane. A lane carrying no packet drives zero.
- R7: Requests accepted in consecutive slots overlap. The row packet of request N+1, the column packet of request N and the data packet of request N−1 start in the same cycle.
- R8: For each lane, the loopback deserializer raises its valid output for one cycle, 8 cycles after the lane's start beat. Its packet output then equals the packet sent, with beat 0 in the lowest bits.
- R9: While reset is held and in the first cycle after it, all lanes are zero and all start, valid and `slotOpen` outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat clock (twice the bus clock rate) |
| rstN | input | 1 | Synchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqRow | input | 12 | Row address |
| reqCol | input | 20 | Column address |
| reqData | input | 128 | Write data |
| slotOpen | output | 1 | A request is accepted in this cycle if `reqValid` is high |
| rowLane | output | 3 | Row lane beat value |
| rowStart | output | 1 | Beat 0 of a row packet |
| colLane | output | 5 | Column lane beat value |
| colStart | output | 1 | Beat 0 of a column packet |
| dataLane | output | 18 | Data lane beat value (data plus parity) |
| dataStart | output | 1 | Beat 0 of a data packet |
| rxRowValid | output | 1 | Rebuilt row packet ready |
| rxRowPkt | output | 24 | Rebuilt row packet |
| rxColValid | output | 1 | Rebuilt column packet ready |
| rxColPkt | output | 40 | Rebuilt column packet |
| rxDataValid | output | 1 | Rebuilt data packet ready |
| rxDataPkt | output | 144 | Rebuilt data packet |

## Verification
With requests in back-to-back slots, three things happen in one cycle: a new request is accepted and loaded into the row shifter, the previous request's column fields move out of the first stage register, and the write data two requests back is loaded from the second stage. The test provokes this by issuing three writes, each in the slot right after the one before, with a maximum-value request in the middle. It judges the result by checking two things. First, the three lanes' start cycles line up in a staircase. Second, each rebuilt packet still matches the request it belongs to, so a stage register overwritten too early shows up as a mixed-up packet.

// File: rtl/pkt_bus_pkg.sv
package pkt_bus_pkg;
  localparam int PKT_BEATS = 8;
  localparam int BEAT_W    = $clog2(PKT_BEATS);

  typedef enum logic {
    CMD_READ  = 1'b0,
    CMD_WRITE = 1'b1
  } cmd_e;

  // strobes from the slot controller to the lane datapath
  typedef struct packed {
    logic advance;    // last beat of a slot
    logic loadRow;    // load row shifter from the accepted request
    logic loadCol;    // load column shifter from stage 1
    logic loadData;   // load data shifter from stage 2
    logic rowAct;     // row lane carries a packet this slot
    logic colAct;
    logic dataAct;
    logic firstBeat;  // beat 0 of the slot
  } txStrobe_t;
endpackage

// File: rtl/pkt_tx_ctrl.sv
module pkt_tx_ctrl
  import pkt_bus_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      reqWrite,
  output logic      slotOpen,
  output txStrobe_t strobe
);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(PKT_BEATS - 1);

  logic [BEAT_W-1:0] beatCnt;
  logic stage1Valid, stage1Write, stage2Write;
  logic rowAct, colAct, dataAct;
  logic advance, accept;

  assign advance = (beatCnt == LAST_BEAT);
  assign accept  = advance && reqValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      beatCnt     <= '0;
      stage1Valid <= 1'b0;
      stage1Write <= 1'b0;
      stage2Write <= 1'b0;
      rowAct      <= 1'b0;
      colAct      <= 1'b0;
      dataAct     <= 1'b0;
    end else begin
      beatCnt <= beatCnt + 1'b1;
      if (advance) begin
        rowAct      <= reqValid;
        colAct      <= stage1Valid;
        dataAct     <= stage2Write;
        stage1Valid <= reqValid;
        stage1Write <= reqValid && reqWrite;
        stage2Write <= stage1Valid && stage1Write;
      end
    end
  end

  assign slotOpen = advance;

  always_comb begin
    strobe           = '0;
    strobe.advance   = advance;
    strobe.loadRow   = accept;
    strobe.loadCol   = advance && stage1Valid;
    strobe.loadData  = advance && stage2Write;
    strobe.rowAct    = rowAct;
    strobe.colAct    = colAct;
    strobe.dataAct   = dataAct;
    strobe.firstBeat = (beatCnt == '0);
  end
endmodule

// File: rtl/pkt_tx_path.sv
module pkt_tx_path
  import pkt_bus_pkg::*;
#(
  parameter int ROW_ADDR_W = 12,
  parameter int COL_ADDR_W = 20,
  parameter int ROW_LANE_W = 3,
  parameter int COL_LANE_W = 5,
  parameter int SLICE_W    = 16,
  parameter int ECC_EN     = 1,
  localparam int PAR_W       = (ECC_EN != 0) ? SLICE_W / 8 : 0,
  localparam int DATA_LANE_W = SLICE_W + PAR_W,
  localparam int DATA_W      = SLICE_W * PKT_BEATS
)(
  input  logic                   clk,
  input  logic                   rstN,
  input  txStrobe_t              strobe,
  input  logic                   reqWrite,
  input  logic [ROW_ADDR_W-1:0]  reqRow,
  input  logic [COL_ADDR_W-1:0]  reqCol,
  input  logic [DATA_W-1:0]      reqData,
  output logic [ROW_LANE_W-1:0]  rowLane,
  output logic                   rowStart,
  output logic [COL_LANE_W-1:0]  colLane,
  output logic                   colStart,
  output logic [DATA_LANE_W-1:0] dataLane,
  output logic                   dataStart
);
  localparam int ROW_PKT_W  = ROW_LANE_W * PKT_BEATS;
  localparam int COL_PKT_W  = COL_LANE_W * PKT_BEATS;
  localparam int DATA_PKT_W = DATA_LANE_W * PKT_BEATS;

  // stage registers holding fields for the later slots
  logic [COL_ADDR_W-1:0] stage1Col;
  logic                  stage1Write;
  logic [DATA_W-1:0]     stage1Data;
  logic [DATA_W-1:0]     stage2Data;

  logic [ROW_PKT_W-1:0]  rowShift, rowPkt;
  logic [COL_PKT_W-1:0]  colShift, colPkt;
  logic [DATA_PKT_W-1:0] dataShift, encData;

  always_comb begin
    rowPkt                 = '0;
    rowPkt[0]              = reqWrite;
    rowPkt[ROW_ADDR_W:1]   = reqRow;
    colPkt                 = '0;
    colPkt[0]              = stage1Write;
    colPkt[COL_ADDR_W:1]   = stage1Col;
  end

  for (genvar b = 0; b < PKT_BEATS; b++) begin : g_beat
    assign encData[b*DATA_LANE_W +: SLICE_W] = stage2Data[b*SLICE_W +: SLICE_W];
    if (ECC_EN != 0) begin : g_par
      for (genvar k = 0; k < PAR_W; k++) begin : g_byte
        assign encData[b*DATA_LANE_W + SLICE_W + k] = ^stage2Data[b*SLICE_W + 8*k +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stage1Col   <= '0;
      stage1Write <= 1'b0;
      stage1Data  <= '0;
      stage2Data  <= '0;
    end else if (strobe.advance) begin
      stage1Col   <= reqCol;
      stage1Write <= reqWrite;
      stage1Data  <= reqData;
      stage2Data  <= stage1Data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowShift  <= '0;
      colShift  <= '0;
      dataShift <= '0;
    end else begin
      rowShift  <= strobe.loadRow  ? rowPkt  : (rowShift  >> ROW_LANE_W);
      colShift  <= strobe.loadCol  ? colPkt  : (colShift  >> COL_LANE_W);
      dataShift <= strobe.loadData ? encData : (dataShift >> DATA_LANE_W);
    end
  end

  assign rowLane   = strobe.rowAct  ? rowShift[ROW_LANE_W-1:0]   : '0;
  assign colLane   = strobe.colAct  ? colShift[COL_LANE_W-1:0]   : '0;
  assign dataLane  = strobe.dataAct ? dataShift[DATA_LANE_W-1:0] : '0;
  assign rowStart  = strobe.rowAct  && strobe.firstBeat;
  assign colStart  = strobe.colAct  && strobe.firstBeat;
  assign dataStart = strobe.dataAct && strobe.firstBeat;
endmodule

// File: rtl/pkt_lane_deser.sv
module pkt_lane_deser
  import pkt_bus_pkg::*;
#(
  parameter int LANE_W = 3,
  localparam int PKT_W = LANE_W * PKT_BEATS
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [LANE_W-1:0] laneIn,
  input  logic              startIn,
  output logic              pktValid,
  output logic [PKT_W-1:0]  pkt
);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(PKT_BEATS - 1);

  logic [PKT_W-1:0]  acc, shifted;
  logic [BEAT_W-1:0] cnt;
  logic              collecting;

  assign shifted = {laneIn, acc[PKT_W-1:LANE_W]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc        <= '0;
      cnt        <= '0;
      collecting <= 1'b0;
      pktValid   <= 1'b0;
      pkt        <= '0;
    end else begin
      pktValid <= 1'b0;
      if (startIn) begin
        acc        <= shifted;
        cnt        <= BEAT_W'(1);
        collecting <= 1'b1;
      end else if (collecting) begin
        acc <= shifted;
        cnt <= cnt + 1'b1;
        if (cnt == LAST_BEAT) begin
          collecting <= 1'b0;
          pkt        <= shifted;
          pktValid   <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pkt_bus_link.sv
module pkt_bus_link
  import pkt_bus_pkg::*;
#(
  parameter int ROW_ADDR_W = 12,
  parameter int COL_ADDR_W = 20,
  parameter int ROW_LANE_W = 3,
  parameter int COL_LANE_W = 5,
  parameter int SLICE_W    = 16,
  parameter int ECC_EN     = 1,
  localparam int PAR_W       = (ECC_EN != 0) ? SLICE_W / 8 : 0,
  localparam int DATA_LANE_W = SLICE_W + PAR_W,
  localparam int DATA_W      = SLICE_W * PKT_BEATS,
  localparam int ROW_PKT_W   = ROW_LANE_W * PKT_BEATS,
  localparam int COL_PKT_W   = COL_LANE_W * PKT_BEATS,
  localparam int DATA_PKT_W  = DATA_LANE_W * PKT_BEATS
)(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  input  logic                   reqWrite,
  input  logic [ROW_ADDR_W-1:0]  reqRow,
  input  logic [COL_ADDR_W-1:0]  reqCol,
  input  logic [DATA_W-1:0]      reqData,
  output logic                   slotOpen,
  output logic [ROW_LANE_W-1:0]  rowLane,
  output logic                   rowStart,
  output logic [COL_LANE_W-1:0]  colLane,
  output logic                   colStart,
  output logic [DATA_LANE_W-1:0] dataLane,
  output logic                   dataStart,
  output logic                   rxRowValid,
  output logic [ROW_PKT_W-1:0]   rxRowPkt,
  output logic                   rxColValid,
  output logic [COL_PKT_W-1:0]   rxColPkt,
  output logic                   rxDataValid,
  output logic [DATA_PKT_W-1:0]  rxDataPkt
);
  txStrobe_t strobe;

  pkt_tx_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .slotOpen(slotOpen), .strobe(strobe)
  );

  pkt_tx_path #(
    .ROW_ADDR_W(ROW_ADDR_W), .COL_ADDR_W(COL_ADDR_W),
    .ROW_LANE_W(ROW_LANE_W), .COL_LANE_W(COL_LANE_W),
    .SLICE_W(SLICE_W), .ECC_EN(ECC_EN)
  ) path_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqWrite(reqWrite),
    .reqRow(reqRow), .reqCol(reqCol), .reqData(reqData),
    .rowLane(rowLane), .rowStart(rowStart),
    .colLane(colLane), .colStart(colStart),
    .dataLane(dataLane), .dataStart(dataStart)
  );

  pkt_lane_deser #(.LANE_W(ROW_LANE_W)) rowRx_i (
    .clk(clk), .rstN(rstN), .laneIn(rowLane), .startIn(rowStart),
    .pktValid(rxRowValid), .pkt(rxRowPkt)
  );

  pkt_lane_deser #(.LANE_W(COL_LANE_W)) colRx_i (
    .clk(clk), .rstN(rstN), .laneIn(colLane), .startIn(colStart),
    .pktValid(rxColValid), .pkt(rxColPkt)
  );

  pkt_lane_deser #(.LANE_W(DATA_LANE_W)) dataRx_i (
    .clk(clk), .rstN(rstN), .laneIn(dataLane), .startIn(dataStart),
    .pktValid(rxDataValid), .pkt(rxDataPkt)
  );
endmodule

// File: rtl/pkt_bus_link_chk.sv
module pkt_bus_link_chk (
  input logic clk,
  input logic rstN,
  input logic reqValid,
  input logic reqWrite,
  input logic slotOpen,
  input logic rowStart,
  input logic colStart,
  input logic dataStart,
  input logic rxRowValid,
  input logic rxColValid,
  input logic rxDataValid
);
  a_r1_take_on_open: assert property (@(posedge clk) disable iff (!rstN)
    (slotOpen && reqValid) |=> rowStart);
  a_r1_no_stray_row: assert property (@(posedge clk) disable iff (!rstN)
    rowStart |-> $past(slotOpen && reqValid));
  a_r1_open_spacing: assert property (@(posedge clk) disable iff (!rstN)
    slotOpen |=> !slotOpen);
  a_r3_col_after_row: assert property (@(posedge clk) disable iff (!rstN)
    colStart |-> $past(rowStart, 8));
  a_r4_data_after_col: assert property (@(posedge clk) disable iff (!rstN)
    dataStart |-> $past(colStart, 8));
  a_r5_data_only_write: assert property (@(posedge clk) disable iff (!rstN)
    dataStart |-> $past(slotOpen && reqValid && reqWrite, 17));
  a_r8_row_rebuilt: assert property (@(posedge clk) disable iff (!rstN)
    rxRowValid |-> $past(rowStart, 8));
  a_r8_col_rebuilt: assert property (@(posedge clk) disable iff (!rstN)
    rxColValid |-> $past(colStart, 8));
  a_r8_data_rebuilt: assert property (@(posedge clk) disable iff (!rstN)
    rxDataValid |-> $past(dataStart, 8));
  a_r9_reset_quiet: assert property (@(posedge clk)
    !rstN |=> !(slotOpen || rowStart || colStart || dataStart || rxRowValid));
endmodule

bind pkt_bus_link pkt_bus_link_chk chk_i (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
  .slotOpen(slotOpen), .rowStart(rowStart), .colStart(colStart),
  .dataStart(dataStart), .rxRowValid(rxRowValid), .rxColValid(rxColValid),
  .rxDataValid(rxDataValid)
);

// File: tb/pkt_bus_link_tb_top.sv
module pkt_bus_link_tb_top;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         reqValid = 1'b0, reqWrite = 1'b0;
  logic [11:0]  reqRow = '0;
  logic [19:0]  reqCol = '0;
  logic [127:0] reqData = '0;
  logic         slotOpen, rowStart, colStart, dataStart;
  logic [2:0]   rowLane;
  logic [4:0]   colLane;
  logic [17:0]  dataLane;
  logic         rxRowValid, rxColValid, rxDataValid;
  logic [23:0]  rxRowPkt;
  logic [39:0]  rxColPkt;
  logic [143:0] rxDataPkt;

  always #2 clk = ~clk;

  pkt_bus_link dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqRow(reqRow), .reqCol(reqCol), .reqData(reqData), .slotOpen(slotOpen),
    .rowLane(rowLane), .rowStart(rowStart), .colLane(colLane), .colStart(colStart),
    .dataLane(dataLane), .dataStart(dataStart),
    .rxRowValid(rxRowValid), .rxRowPkt(rxRowPkt), .rxColValid(rxColValid),
    .rxColPkt(rxColPkt), .rxDataValid(rxDataValid), .rxDataPkt(rxDataPkt)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [143:0] act, input logic [143:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- expected packet builders
  function automatic logic [23:0] expRow(input logic [11:0] r, input bit wr);
    logic [23:0] p = '0;
    p[0] = wr; p[12:1] = r;
    return p;
  endfunction
  function automatic logic [39:0] expCol(input logic [19:0] c, input bit wr);
    logic [39:0] p = '0;
    p[0] = wr; p[20:1] = c;
    return p;
  endfunction
  function automatic logic [143:0] expData(input logic [127:0] d);
    logic [143:0] p = '0;
    for (int b = 0; b < 8; b++) begin
      logic [15:0] s = d[16*b +: 16];
      p[18*b +: 16] = s;
      p[18*b + 16]  = ^s[7:0];
      p[18*b + 17]  = ^s[15:8];
    end
    return p;
  endfunction

  // ---------------- lane monitors
  logic [23:0]  rowRec[32];  int rowCycRec[32];  int nRow = 0;
  logic [39:0]  colRec[32];  int colCycRec[32];  int nCol = 0;
  logic [143:0] datRec[32];  int datCycRec[32];  int nDat = 0;
  logic [23:0]  rxRowRec[32]; int rxRowCyc[32]; int nRxRow = 0;
  logic [39:0]  rxColRec[32]; int rxColCyc[32]; int nRxCol = 0;
  logic [143:0] rxDatRec[32]; int rxDatCyc[32]; int nRxDat = 0;
  int idleErr = 0, startErr = 0;
  int rB = 0, cB = 0, dB = 0, rC0 = 0, cC0 = 0, dC0 = 0;
  logic [23:0] rA; logic [39:0] cA; logic [143:0] dA;

  always @(negedge clk) if (rstN) begin
    if (rowStart && rB > 0) startErr++;
    if (rowStart) begin rA = 24'(rowLane); rB = 1; rC0 = cyc; end
    else if (rB > 0) begin rA = rA | (24'(rowLane) << (3*rB)); rB++; end
    else if (rowLane != '0) idleErr++;
    if (rB == 8) begin if (nRow < 32) begin rowRec[nRow] = rA; rowCycRec[nRow] = rC0; nRow++; end rB = 0; end

    if (colStart && cB > 0) startErr++;
    if (colStart) begin cA = 40'(colLane); cB = 1; cC0 = cyc; end
    else if (cB > 0) begin cA = cA | (40'(colLane) << (5*cB)); cB++; end
    else if (colLane != '0) idleErr++;
    if (cB == 8) begin if (nCol < 32) begin colRec[nCol] = cA; colCycRec[nCol] = cC0; nCol++; end cB = 0; end

    if (dataStart && dB > 0) startErr++;
    if (dataStart) begin dA = 144'(dataLane); dB = 1; dC0 = cyc; end
    else if (dB > 0) begin dA = dA | (144'(dataLane) << (18*dB)); dB++; end
    else if (dataLane != '0) idleErr++;
    if (dB == 8) begin if (nDat < 32) begin datRec[nDat] = dA; datCycRec[nDat] = dC0; nDat++; end dB = 0; end

    if (rxRowValid && nRxRow < 32) begin rxRowRec[nRxRow] = rxRowPkt; rxRowCyc[nRxRow] = cyc; nRxRow++; end
    if (rxColValid && nRxCol < 32) begin rxColRec[nRxCol] = rxColPkt; rxColCyc[nRxCol] = cyc; nRxCol++; end
    if (rxDataValid && nRxDat < 32) begin rxDatRec[nRxDat] = rxDataPkt; rxDatCyc[nRxDat] = cyc; nRxDat++; end
  end

  // ---------------- stimulus helpers
  task automatic sendReq(input bit wr, input logic [11:0] r, input logic [19:0] c,
                         input logic [127:0] d, output int acc);
    @(negedge clk);
    while (!slotOpen) @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqRow = r; reqCol = c; reqData = d;
    acc = cyc + 1;
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0; reqRow = '0; reqCol = '0; reqData = '0;
  endtask

  task automatic t_reset();
    chk(slotOpen == 1'b0 && rowStart == 1'b0 && colStart == 1'b0 && dataStart == 1'b0,
        "R9 flags in reset", {slotOpen, rowStart, colStart, dataStart}, 0);
    chk(rowLane == '0 && colLane == '0 && dataLane == '0, "R9 lanes in reset",
        {rowLane, colLane, dataLane}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!slotOpen && !rxRowValid && !rxColValid && !rxDataValid && dataLane == '0,
        "R9 first cycle after reset", {slotOpen, rxRowValid, rxColValid, rxDataValid}, 0);
  endtask

  task automatic t_single_write();
    int acc;
    int r0 = nRow, c0 = nCol, d0 = nDat, x0 = nRxRow, y0 = nRxCol, z0 = nRxDat;
    logic [127:0] d = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
    sendReq(1'b1, 12'hA5C, 20'h3_1F2E, d, acc);
    repeat (30) @(negedge clk);
    chk(nRow == r0 + 1 && rowRec[r0] == expRow(12'hA5C, 1'b1), "R2 row packet", rowRec[r0], expRow(12'hA5C, 1'b1));
    chk(rowCycRec[r0] == acc, "R2 row start cycle", rowCycRec[r0], acc);
    chk(nCol == c0 + 1 && colRec[c0] == expCol(20'h3_1F2E, 1'b1), "R3 column packet", colRec[c0], expCol(20'h3_1F2E, 1'b1));
    chk(colCycRec[c0] == acc + 8, "R3 column start cycle", colCycRec[c0], acc + 8);
    chk(nDat == d0 + 1 && datRec[d0] == expData(d), "R4 data packet", datRec[d0], expData(d));
    chk(datCycRec[d0] == acc + 16, "R4 data start cycle", datCycRec[d0], acc + 16);
    chk(nRxRow == x0 + 1 && rxRowRec[x0] == expRow(12'hA5C, 1'b1) && rxRowCyc[x0] == acc + 8,
        "R8 row rebuilt", rxRowRec[x0], expRow(12'hA5C, 1'b1));
    chk(nRxCol == y0 + 1 && rxColRec[y0] == expCol(20'h3_1F2E, 1'b1) && rxColCyc[y0] == acc + 16,
        "R8 column rebuilt", rxColRec[y0], expCol(20'h3_1F2E, 1'b1));
    chk(nRxDat == z0 + 1 && rxDatRec[z0] == expData(d) && rxDatCyc[z0] == acc + 24,
        "R8 data rebuilt", rxDatRec[z0], expData(d));
  endtask

  task automatic t_read();
    int acc;
    int r0 = nRow, c0 = nCol, d0 = nDat, z0 = nRxDat;
    sendReq(1'b0, 12'h3C3, 20'hF_0001, {4{32'hDEAD_BEEF}}, acc);
    repeat (30) @(negedge clk);
    chk(nRow == r0 + 1 && rowRec[r0] == expRow(12'h3C3, 1'b0), "R2 read row packet cmd 0", rowRec[r0], expRow(12'h3C3, 1'b0));
    chk(nCol == c0 + 1 && colRec[c0] == expCol(20'hF_0001, 1'b0), "R3 read column packet cmd 0", colRec[c0], expCol(20'hF_0001, 1'b0));
    chk(nDat == d0 && nRxDat == z0, "R5 read sends no data packet", nDat - d0, 0);
  endtask

  task automatic t_ignored();
    int r0 = nRow;
    @(negedge clk);
    while (!slotOpen) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqRow = 12'h7FF;
    repeat (6) @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0; reqRow = '0;
    repeat (30) @(negedge clk);
    chk(nRow == r0, "R1 request outside open slot ignored", nRow - r0, 0);
  endtask

  task automatic t_back_to_back();
    int a0, a1, a2;
    int r0 = nRow, c0 = nCol, d0 = nDat, z0 = nRxDat;
    logic [127:0] dA0 = {8{16'h1234}}, dA1 = '1, dA2 = {16{8'h81}};
    sendReq(1'b1, 12'h001, 20'h0_0011, dA0, a0);
    sendReq(1'b1, 12'hFFF, 20'hF_FFFF, dA1, a1);
    sendReq(1'b1, 12'h800, 20'h8_0000, dA2, a2);
    repeat (40) @(negedge clk);
    chk(a1 == a0 + 8 && a2 == a1 + 8, "R7 requests taken in consecutive slots", a2 - a0, 16);
    chk(rowCycRec[r0 + 2] == colCycRec[c0 + 1] && colCycRec[c0 + 1] == datCycRec[d0],
        "R7 row N+1, col N, data N-1 same cycle", rowCycRec[r0 + 2], datCycRec[d0]);
    chk(rowRec[r0 + 1] == expRow(12'hFFF, 1'b1), "R2 max row packet", rowRec[r0 + 1], expRow(12'hFFF, 1'b1));
    chk(colRec[c0 + 1] == expCol(20'hF_FFFF, 1'b1), "R3 max column packet", colRec[c0 + 1], expCol(20'hF_FFFF, 1'b1));
    chk(colRec[c0 + 2] == expCol(20'h8_0000, 1'b1), "R3 third column packet", colRec[c0 + 2], expCol(20'h8_0000, 1'b1));
    chk(datRec[d0] == expData(dA0) && datRec[d0 + 1] == expData(dA1) && datRec[d0 + 2] == expData(dA2),
        "R4 overlapped data packets", datRec[d0 + 1], expData(dA1));
    chk(nRxDat == z0 + 3 && rxDatRec[z0 + 1] == expData(dA1) && rxDatRec[z0 + 2] == expData(dA2),
        "R8 overlapped data rebuilt", rxDatRec[z0 + 1], expData(dA1));
  endtask

  task automatic t_lane_hygiene();
    chk(idleErr == 0, "R6 idle lanes drive zero", idleErr, 0);
    chk(startErr == 0, "R6 start flag only on beat 0", startErr, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_single_write();
    t_read();
    t_ignored();
    t_back_to_back();
    t_lane_hygiene();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule